// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Decoder

This block is a clocked front end for a byte-wide asynchronous static-memory bus. It oversamples three active-low strobes: chip select, write strobe and output strobe. It also samples an address and a write-data bus. From these samples it rebuilds read and write cycles and drives an internal synchronous byte array. The tri-state data bus is split into a data output and an output-drive qualifier, so the pad ring owns the bidirectional buffer.

All strobes, the address, the write data and a supervisor protect line go through one common two-stage synchronizer, which keeps them aligned. Every later decision uses the synchronized samples. The write interval is the overlap of chip select and write strobe, whichever of the two edges bounds it. Read data is presented from a registered array read port. A write that breaks the cycle rules is dropped and reported on a one-cycle error pulse. The external address is 17 bits wide. The array holds 2**MEM_AW bytes and is indexed by the low MEM_AW address bits.

Top module: `sram_cycle_frontend`

## Requirements
- R1: While chip select and output strobe are low and write strobe is high, the output presents the byte stored at the sampled address and `dout_en` is 1. This appears on the third rising clock edge after the pins settle.
- R2: `dout_en` is 1 only when chip select, output strobe and protect were sampled low and write strobe was sampled high. In every other combination it is 0.
- R3: If write strobe falls while the outputs are driven, `dout_en` returns to 0. If chip select and write strobe fall in the same sample, `dout_en` stays 0 for the whole cycle.
- R4: A write interval is open while chip select and write strobe are both sampled low. It begins at the later of their falling edges, in either order. Exactly one byte is committed, at the first sample in which either strobe is high again.
- R5: The committed byte is the write data of the last sample inside the interval, not the value at its start.
- R6: The interval closes on whichever strobe rises first. A close by chip select and a close by write strobe both commit the byte.
- R7: If the address differs from its value at the interval start, the write is dropped and `proto_err` pulses high for one cycle.
- R8: After an interval closes, at least RECOV_CYC samples with the interval closed must pass, counting the closing sample. An interval that opens sooner is dropped and `proto_err` pulses.
- R9: While `prot` is high, `dout_en` is 0. A write interval that sees `prot` high in any of its samples, including the closing one, commits nothing.
- R10: After reset, `dout_en` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| prot | input | 1 | Supervisor protect: blocks writes and output drive |
| addr | input | ADDR_W (17) | Byte address |
| din | input | DW (8) | Write data from the bus |
| dout | output | DW (8) | Read data toward the bus |
| dout_en | output | 1 | Drive enable for the bus buffer |
| proto_err | output | 1 | One-cycle pulse when a write is dropped for a rule violation |

## Verification
The hardest conditions to reach are the rule violations that only a badly behaved bus master produces. Examples are an interval reopened before the recovery count has run out, an address that moves in mid-interval, and a chip select that falls in the same sample as the write strobe. The bench drives each pin pattern from its own task at the falling clock edge, so the number of samples in each phase is exact. It then reads the target bytes back through normal read cycles to show which writes landed. The recovery case is run with a gap of two samples, which must be rejected, and a gap of eight, which must be accepted.

// File: rtl/sramfe_pkg.sv
package sramfe_pkg;
  typedef struct packed {
    logic prot;
    logic oe_n;
    logic we_n;
    logic ce_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{prot: 1'b0, oe_n: 1'b1, we_n: 1'b1, ce_n: 1'b1};
endpackage

// File: rtl/sramfe_sync.sv
module sramfe_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sramfe_mem.sv
module sramfe_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/sramfe_cycle.sv
module sramfe_cycle #(
  parameter int ADDR_W    = 17,
  parameter int MEM_AW    = 11,
  parameter int DW        = 8,
  parameter int RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_ce_n,
  input  logic              s_we_n,
  input  logic              s_oe_n,
  input  logic              s_prot,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DW-1:0]     s_din,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              drive,
  output logic              err_pulse
);
  localparam int CW = $clog2(RECOV_CYC + 1);

  logic              win, win_q, opening, closing, mismatch, rec_busy;
  logic              kill_q, mis_q;
  logic [CW-1:0]     rec_cnt;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DW-1:0]     wr_data_q;

  assign win      = ~s_ce_n & ~s_we_n;
  assign opening  = win & ~win_q;
  assign closing  = ~win & win_q;
  assign rec_busy = (rec_cnt != '0);
  assign mismatch = win & win_q & (s_addr != wr_addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= 1'b0;
      kill_q    <= 1'b0;
      mis_q     <= 1'b0;
      err_pulse <= 1'b0;
      rec_cnt   <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      win_q     <= win;
      err_pulse <= 1'b0;
      if (opening) begin
        wr_addr_q <= s_addr;
        wr_data_q <= s_din;
        kill_q    <= s_prot | rec_busy;
        mis_q     <= 1'b0;
        err_pulse <= rec_busy;
      end else if (win) begin
        wr_data_q <= s_din;
        if (s_prot) kill_q <= 1'b1;
        if (mismatch) begin
          mis_q     <= 1'b1;
          err_pulse <= ~mis_q;
        end
      end
      if (closing)
        rec_cnt <= CW'(RECOV_CYC - 1);
      else if (!win && rec_busy)
        rec_cnt <= rec_cnt - 1'b1;
    end
  end

  assign wr_en   = closing & ~kill_q & ~mis_q & ~s_prot;
  assign wr_addr = wr_addr_q[MEM_AW-1:0];
  assign wr_data = wr_data_q;
  assign drive   = ~s_ce_n & ~s_oe_n & s_we_n & ~s_prot;
endmodule

// File: rtl/sram_cycle_frontend.sv
module sram_cycle_frontend
  import sramfe_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int MEM_AW    = 11,
  parameter int DW        = 8,
  parameter int SYNC_STG  = 2,
  parameter int RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              prot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  output logic              proto_err
);
  localparam int BW = $bits(strobe_t) + ADDR_W + DW;
  localparam logic [BW-1:0] BUS_RST = {STROBE_IDLE, {(ADDR_W + DW){1'b0}}};

  strobe_t           s_str;
  logic [ADDR_W-1:0] s_addr;
  logic [DW-1:0]     s_din;
  logic              s_ce_n, s_we_n, s_oe_n, s_prot;
  logic              mem_we, drive;
  logic [MEM_AW-1:0] mem_waddr;
  logic [DW-1:0]     mem_wdata;
  logic [BW-1:0]     raw_bus, s_bus;

  assign raw_bus = {prot, oe_n, we_n, ce_n, addr, din};

  sramfe_sync #(.W(BW), .STAGES(SYNC_STG), .RST_VAL(BUS_RST)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (s_bus)
  );

  assign {s_str, s_addr, s_din} = s_bus;
  assign s_ce_n = s_str.ce_n;
  assign s_we_n = s_str.we_n;
  assign s_oe_n = s_str.oe_n;
  assign s_prot = s_str.prot;

  sramfe_cycle #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DW(DW), .RECOV_CYC(RECOV_CYC)) cyc_i (
    .clk       (clk),
    .rst       (rst),
    .s_ce_n    (s_ce_n),
    .s_we_n    (s_we_n),
    .s_oe_n    (s_oe_n),
    .s_prot    (s_prot),
    .s_addr    (s_addr),
    .s_din     (s_din),
    .wr_en     (mem_we),
    .wr_addr   (mem_waddr),
    .wr_data   (mem_wdata),
    .drive     (drive),
    .err_pulse (proto_err)
  );

  sramfe_mem #(.AW(MEM_AW), .DW(DW)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (s_addr[MEM_AW-1:0]),
    .rdata (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_en <= 1'b0;
    else     dout_en <= drive;
  end
endmodule

// File: rtl/sramfe_chk.sv
module sramfe_chk (
  input logic clk,
  input logic rst,
  input logic s_ce_n,
  input logic s_we_n,
  input logic s_oe_n,
  input logic s_prot,
  input logic mem_we,
  input logic dout_en
);
  AST_DRIVE_NEEDS_READ_MODE: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(!s_ce_n && !s_oe_n && s_we_n)); // R2
  AST_DRIVE_OFF_UNDER_PROT: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !$past(s_prot)); // R9
  AST_COMMIT_AFTER_OPEN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(!s_ce_n && !s_we_n)); // R4
  AST_COMMIT_CLOSED_NOW: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (s_ce_n || s_we_n)); // R6
  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4
  AST_PROT_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(s_prot)); // R9
endmodule

bind sram_cycle_frontend sramfe_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .s_ce_n  (s_ce_n),
  .s_we_n  (s_we_n),
  .s_oe_n  (s_oe_n),
  .s_prot  (s_prot),
  .mem_we  (mem_we),
  .dout_en (dout_en)
);

// File: tb/sram_cycle_frontend_tb.sv
module sram_cycle_frontend_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, prot = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en, proto_err;

  int checks = 0;
  int failures = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_cycle_frontend dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .prot(prot),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .proto_err(proto_err)
  );

  always @(posedge clk) if (!rst && proto_err) err_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // write strobe falls after chip select, closes by write strobe
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
    cyc(1); we_n = 1'b0;
    cyc(2); we_n = 1'b1;
    cyc(1); ce_n = 1'b1;
    cyc(8);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic en);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    cyc(4);
    v = dout; en = dout_en;
    idle();
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R10 dout_en after reset", int'(dout_en), 0);
    chk("R10 proto_err after reset", int'(proto_err), 0);
  endtask

  task automatic t_basic_rw();
    logic [DW-1:0] v; logic en;
    wr(17'h00010, 8'hA5);
    wr(17'h00011, 8'h3C);
    rd(17'h00010, v, en);
    chk("R1 read data", int'(v), 8'hA5);
    chk("R1 read drive", int'(en), 1);
    rd(17'h00011, v, en);
    chk("R4 second write", int'(v), 8'h3C);
  endtask

  task automatic t_drive_rules();
    @(negedge clk);
    addr = 17'h00010; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    cyc(4); chk("R2 output strobe high", int'(dout_en), 0);
    ce_n = 1'b1; oe_n = 1'b0;
    cyc(4); chk("R2 chip select high", int'(dout_en), 0);
    idle(); cyc(4);
  endtask

  task automatic t_wfall_cut();
    @(negedge clk);
    addr = 17'h00010; din = 8'hA5; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(4); chk("R3 driving before strobe", int'(dout_en), 1);
    we_n = 1'b0;
    cyc(4); chk("R3 drive off after write strobe falls", int'(dout_en), 0);
    idle(); cyc(8);
  endtask

  task automatic t_simul_fall();
    logic [DW-1:0] v; logic en;
    int seen = 0;
    @(negedge clk);
    addr = 17'h00020; din = 8'h77; oe_n = 1'b0;
    cyc(1);
    ce_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dout_en) seen++;
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (dout_en) seen++;
    end
    chk("R3 no drive on joint fall", seen, 0);
    cyc(6);
    rd(17'h00020, v, en);
    chk("R4 joint fall commits", int'(v), 8'h77);
  endtask

  task automatic t_ce_ordered();
    logic [DW-1:0] v; logic en;
    @(negedge clk);
    addr = 17'h00030; din = 8'h5A; we_n = 1'b0;
    cyc(2); ce_n = 1'b0;
    cyc(2); ce_n = 1'b1;
    cyc(1); we_n = 1'b1;
    cyc(8);
    rd(17'h00030, v, en);
    chk("R6 close by chip select", int'(v), 8'h5A);
  endtask

  task automatic t_last_data();
    logic [DW-1:0] v; logic en;
    @(negedge clk);
    addr = 17'h00040; din = 8'h51; ce_n = 1'b0; we_n = 1'b0;
    cyc(2); din = 8'h52;
    cyc(1); we_n = 1'b1; din = 8'h53;
    cyc(1); ce_n = 1'b1;
    cyc(8);
    rd(17'h00040, v, en);
    chk("R5 last in-window data", int'(v), 8'h52);
  endtask

  task automatic t_addr_move();
    logic [DW-1:0] v; logic en;
    int e0;
    wr(17'h00050, 8'h30);
    wr(17'h00051, 8'h40);
    e0 = err_cnt;
    @(negedge clk);
    addr = 17'h00050; din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
    cyc(2); addr = 17'h00051;
    cyc(2); idle();
    cyc(8);
    chk("R7 error pulse count", err_cnt - e0, 1);
    rd(17'h00050, v, en);
    chk("R7 first addr untouched", int'(v), 8'h30);
    rd(17'h00051, v, en);
    chk("R7 second addr untouched", int'(v), 8'h40);
  endtask

  task automatic t_recovery();
    logic [DW-1:0] v; logic en;
    int e0;
    wr(17'h00061, 8'h20);
    e0 = err_cnt;
    @(negedge clk);
    addr = 17'h00060; din = 8'h21; ce_n = 1'b0; we_n = 1'b0;
    cyc(2); idle();
    cyc(2);
    addr = 17'h00061; din = 8'h22; ce_n = 1'b0; we_n = 1'b0;
    cyc(2); idle();
    cyc(8);
    chk("R8 early reopen flagged", err_cnt - e0, 1);
    rd(17'h00060, v, en);
    chk("R8 first write kept", int'(v), 8'h21);
    rd(17'h00061, v, en);
    chk("R8 early write dropped", int'(v), 8'h20);
    wr(17'h00061, 8'h23);
    rd(17'h00061, v, en);
    chk("R8 spaced write accepted", int'(v), 8'h23);
    chk("R8 no error when spaced", err_cnt - e0, 1);
  endtask

  task automatic t_protect();
    logic [DW-1:0] v; logic en;
    wr(17'h00070, 8'h11);
    prot = 1'b1;
    wr(17'h00070, 8'hEE);
    rd(17'h00070, v, en);
    chk("R9 no drive under protect", int'(en), 0);
    prot = 1'b0;
    cyc(4);
    rd(17'h00070, v, en);
    chk("R9 write blocked", int'(v), 8'h11);
    chk("R1 drive back after protect", int'(en), 1);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(4);
    t_reset();
    t_basic_rw();
    t_drive_rules();
    t_wfall_cut();
    t_simul_fall();
    t_ce_ordered();
    t_last_data();
    t_addr_move();
    t_recovery();
    t_protect();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule